// File: doc/BRIEF.md
# Razor Timing-Error Register

This block is a register bank for one multi-bit datapath result. It samples the result twice. The main register takes it on the normal clock edge. A shadow stage takes it again on a delayed clock that lags the normal clock by less than half a period. A result that arrives after the normal edge but before the delayed edge leaves the two copies different. The block compares them bit by bit, then copies the shadow value into the main register and raises a one-cycle error flag. A downstream controller uses that flag to replay the operation and to track how often late results occur.

The result path has no valid/ready handshake and no back-pressure, because the block can never stall. Any new word offered on the normal edge where a correction takes place is dropped. Upstream logic must repeat that word, which it does when it replays on the error flag.

On the edge after a correction, the shadow stage has already sampled a new word while the main register still holds the restored one. That edge therefore skips the comparison.

Top module: `razor_reg`

## Requirements
- R1: With no correction pending, every normal-clock edge loads `data_in` into `data_out` and leaves `timing_err` at 0.
- R2: The shadow copy samples `data_in` on the rising edge of `clk_late`. That edge comes after the `clk_main` edge and before the falling edge of `clk_main`.
- R3: If the main register and the shadow copy differ in any bit (lowest, highest, a middle bit, or all bits), the next normal-clock edge raises `timing_err`.
- R4: On that edge, `data_out` takes the shadow value captured after the late edge, not the current `data_in`.
- R5: `timing_err` stays high for exactly one normal-clock cycle per detected mismatch.
- R6: The normal-clock edge after a correction skips the comparison. It loads `data_in` and keeps `timing_err` low, even when the shadow sampled a different word. The word presented on the correction edge itself is lost.
- R7: While the active-high synchronous reset `rst` is high, the main register, the shadow copy and the error flag clear to 0. No false error follows the release of reset.
- R8: The word width is a parameter with a default of 32 bits. The mismatch check covers every bit of the word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_main | input | 1 | Normal sampling clock |
| clk_late | input | 1 | Delayed copy of the clock for the shadow stage |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| data_in | input | WIDTH | Datapath result to be registered |
| data_out | output | WIDTH | Registered, self-corrected result |
| timing_err | output | 1 | One-cycle pulse marking a late-arriving result |

## Verification
The hardest case to produce from the ports is a late arrival: a word that changes after the normal edge but before the delayed edge. The stimulus produces it by writing one value just before the normal edge and a second value one time unit after it. The main register and the shadow copy then hold chosen different words.

The same control reaches the edge after a correction with a shadow word that deliberately differs from the restored value. This shows that the comparison is skipped and that the word offered on the correction edge is dropped. Runs of consecutive late cycles and a reset applied while a mismatch is pending cover the remaining orderings.

// File: rtl/razor_pkg.sv
package razor_pkg;
  typedef enum logic {
    CAP_DATA   = 1'b0,
    CAP_SHADOW = 1'b1
  } cap_src_e;

  function automatic int lane_count(input int width, input int lane_w);
    return (width + lane_w - 1) / lane_w;
  endfunction
endpackage

// File: rtl/razor_shadow.sv
module razor_shadow #(
  parameter int WIDTH = 32
) (
  input  logic             clk_late,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] sh_o
);
  always_ff @(posedge clk_late) begin
    if (rst) sh_o <= '0;
    else     sh_o <= d_i;
  end

  AST_SHADOW_CLEAR: assert property (@(posedge clk_late)
    rst |=> (sh_o == '0)); // R7
endmodule

// File: rtl/razor_cmp.sv
module razor_cmp #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8
) (
  input  logic [WIDTH-1:0] main_i,
  input  logic [WIDTH-1:0] sh_i,
  output logic             mism_o
);
  localparam int NLANE = razor_pkg::lane_count(WIDTH, LANE_W);

  logic [NLANE-1:0] lane_m;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    localparam int LO = g * LANE_W;
    localparam int HI = ((g + 1) * LANE_W > WIDTH) ? WIDTH - 1 : (g + 1) * LANE_W - 1;
    assign lane_m[g] = |(main_i[HI:LO] ^ sh_i[HI:LO]);
  end

  assign mism_o = |lane_m;
endmodule

// File: rtl/razor_main.sv
module razor_main
  import razor_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk_main,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  input  logic [WIDTH-1:0] shadow_i,
  input  logic             mism_i,
  output logic [WIDTH-1:0] q_o,
  output logic             err_o
);
  logic     rec_q;
  cap_src_e src;

  assign src = (!rec_q && mism_i) ? CAP_SHADOW : CAP_DATA;

  always_ff @(posedge clk_main) begin
    if (rst) begin
      q_o   <= '0;
      err_o <= 1'b0;
      rec_q <= 1'b0;
    end else if (src == CAP_SHADOW) begin
      q_o   <= shadow_i;
      err_o <= 1'b1;
      rec_q <= 1'b1;
    end else begin
      q_o   <= d_i;
      err_o <= 1'b0;
      rec_q <= 1'b0;
    end
  end

  AST_FRESH_LOAD: assert property (@(posedge clk_main) disable iff (rst)
    (!mism_i) |=> (q_o == $past(d_i)) && !err_o); // R1
  AST_RESTORE: assert property (@(posedge clk_main) disable iff (rst)
    (!rec_q && mism_i) |=> err_o && (q_o == $past(shadow_i))); // R4
  AST_ERR_PULSE: assert property (@(posedge clk_main) disable iff (rst)
    err_o |=> !err_o); // R5
  AST_SKIP_AFTER_FIX: assert property (@(posedge clk_main) disable iff (rst)
    rec_q |=> (q_o == $past(d_i)) && !err_o); // R6
  AST_RESET_CLEAR: assert property (@(posedge clk_main)
    rst |=> (q_o == '0) && !err_o); // R7
endmodule

// File: rtl/razor_reg.sv
module razor_reg #(
  parameter int WIDTH  = 32,
  parameter int LANE_W = 8
) (
  input  logic             clk_main,
  input  logic             clk_late,
  input  logic             rst,
  input  logic [WIDTH-1:0] data_in,
  output logic [WIDTH-1:0] data_out,
  output logic             timing_err
);
  logic [WIDTH-1:0] sh;
  logic             mism;

  razor_shadow #(.WIDTH(WIDTH)) u_shadow (
    .clk_late (clk_late),
    .rst      (rst),
    .d_i      (data_in),
    .sh_o     (sh)
  );

  razor_cmp #(.WIDTH(WIDTH), .LANE_W(LANE_W)) u_cmp (
    .main_i (data_out),
    .sh_i   (sh),
    .mism_o (mism)
  );

  razor_main #(.WIDTH(WIDTH)) u_main (
    .clk_main (clk_main),
    .rst      (rst),
    .d_i      (data_in),
    .shadow_i (sh),
    .mism_i   (mism),
    .q_o      (data_out),
    .err_o    (timing_err)
  );
endmodule

// File: tb/sim_razor_reg.sv
module sim_razor_reg;
  localparam int CLK_T = 10;
  localparam int LAG   = 3;
  localparam int W     = 32;

  logic         clk_main, clk_late, rst;
  logic [W-1:0] data_in;
  logic [W-1:0] data_out;
  logic         timing_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W:0] expq[$];
  string      tagq[$];

  logic [W-1:0] m_q, m_sh;
  bit           m_rec;

  razor_reg #(.WIDTH(W)) u0 (
    .clk_main   (clk_main),
    .clk_late   (clk_late),
    .rst        (rst),
    .data_in    (data_in),
    .data_out   (data_out),
    .timing_err (timing_err)
  );

  initial begin
    clk_main = 0;
    forever #(CLK_T/2) clk_main = ~clk_main;
  end

  initial begin
    clk_late = 0;
    #LAG;
    forever #(CLK_T/2) clk_late = ~clk_late;
  end

  task automatic chk(string tag, logic [W-1:0] aq, logic [W-1:0] eq, logic ae, logic ee);
    total++;
    if (aq !== eq || ae !== ee) begin
      bad++;
      $display("FAIL %s data_out=%h exp=%h timing_err=%b exp=%b", tag, aq, eq, ae, ee);
    end
  endtask

  // One normal cycle: a is present at the normal edge, b at the delayed edge.
  task automatic cyc(logic [W-1:0] a, logic [W-1:0] b, string tag);
    logic e;
    @(negedge clk_main);
    data_in = a;
    rst     = 1'b0;
    @(posedge clk_main);
    #1;
    data_in = b;
    if (!m_rec && (m_q != m_sh)) begin
      m_q = m_sh; e = 1'b1; m_rec = 1'b1;
    end else begin
      m_q = a; e = 1'b0; m_rec = 1'b0;
    end
    m_sh = b;
    expq.push_back({e, m_q});
    tagq.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk_main);
    rst     = 1'b1;
    data_in = 32'hDEAD_BEEF;
    repeat (3) @(posedge clk_main);
    #7;
    chk("R7 reset", data_out, '0, timing_err, 1'b0);
    m_q = '0; m_sh = '0; m_rec = 1'b0;
  endtask

  // Scoreboard monitor.
  initial begin
    forever begin
      @(posedge clk_main);
      #7;
      if (expq.size() > 0) begin
        logic [W:0] ex;
        string      tg;
        ex = expq.pop_front();
        tg = tagq.pop_front();
        chk(tg, data_out, ex[W-1:0], timing_err, ex[W]);
      end
    end
  end

  initial begin
    #(CLK_T * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    data_in = 32'hDEAD_BEEF;
    m_q = '0; m_sh = '0; m_rec = 1'b0;
    repeat (3) @(posedge clk_main);
    #7;
    chk("R7 initial reset", data_out, '0, timing_err, 1'b0);

    // R1 R2 R8: clean stream, various patterns
    cyc(32'h0000_0001, 32'h0000_0001, "R7 no false error after release");
    cyc(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1 all ones");
    cyc(32'h8000_0000, 32'h8000_0000, "R1 msb");
    cyc(32'h1234_5678, 32'h1234_5678, "R8 full word");
    cyc(32'hA5A5_5A5A, 32'hA5A5_5A5A, "R2 stable across late edge");

    // R3 R4 R5 R6: late lowest bit
    cyc(32'h0000_0010, 32'h0000_0011, "R1 late lsb load");
    cyc(32'h7777_7777, 32'h2222_2222, "R3 R4 lsb mismatch fixed");
    cyc(32'h3333_3333, 32'h3333_3333, "R5 R6 skip after fix");
    cyc(32'h4444_4444, 32'h4444_4444, "R5 clean again");

    // late highest bit
    cyc(32'h0000_0000, 32'h8000_0000, "R1 late msb load");
    cyc(32'h0BAD_0BAD, 32'h0BAD_0BAD, "R3 R4 msb mismatch fixed");
    cyc(32'h0C0C_0C0C, 32'h0C0C_0C0C, "R6 skip msb case");

    // all bits differ, middle bit
    cyc(32'h5555_5555, 32'hAAAA_AAAA, "R1 late all bits load");
    cyc(32'h1111_1111, 32'h1111_1111, "R3 all bits fixed");
    cyc(32'h0001_0000, 32'h0001_0000, "R6 skip");
    cyc(32'h0000_0000, 32'h0001_0000, "R1 late mid bit load");
    cyc(32'h0000_0000, 32'h0000_0000, "R8 mid bit fixed");
    cyc(32'h0000_0000, 32'h0000_0000, "R6 skip mid");

    // back-to-back late cycles: the second lands on the skip edge
    cyc(32'h0000_00A0, 32'h0000_00A1, "R1 late run 1");
    cyc(32'h0000_00B0, 32'h0000_00B1, "R4 run fix");
    cyc(32'h0000_00C0, 32'h0000_00C1, "R6 run skip ignores shadow");
    cyc(32'h0000_00D0, 32'h0000_00D0, "R3 run second fix");
    cyc(32'h0000_00E0, 32'h0000_00E0, "R5 run pulse ends");

    // reset while a mismatch is pending
    cyc(32'h0F0F_0F0F, 32'hF0F0_F0F0, "R1 before reset");
    do_reset();
    cyc(32'h0000_0042, 32'h0000_0042, "R7 clean after mid reset");
    cyc(32'h0000_0043, 32'h0000_0043, "R7 stays clean");

    repeat (3) @(posedge clk_main);
    #8;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule